// File: doc/BRIEF.md
# Burst Beat Address and Byte-Lane Sequencer

This block turns one burst command into its sequence of beats. A command carries a start address, a transfer size code, a length code and a burst kind, and it is taken on a valid/ready port. The block then presents one beat at a time on a second valid/ready pair. Each beat carries its byte address, the lowest and highest active byte lanes of the data bus, a per-lane strobe mask and a flag on the final beat. The bus width in bytes is a parameter.

A start address that is not aligned to the transfer size keeps its exact value on the first beat, and that beat covers only part of the lane range. Every later beat of an incrementing or wrapping burst is aligned to the transfer size. A wrapping burst folds back to the bottom of a window whose size is the total byte count of the burst. A fixed burst repeats the first beat. Commands that the block cannot sequence are refused with a one-cycle error pulse, and no beats follow them.

Top module: `axbg_burst_gen`

## Requirements
- R1: After reset `beat_valid` and `cmd_err` are 0 and `cmd_ready` is 1. `cmd_ready` is 1 exactly when no burst is active, or when the final beat is presented with `beat_ready` high. When a legal command is accepted at a clock edge, its first beat is presented from that edge on.
- R2: A legal burst presents exactly `cmd_len`+1 beats. `beat_last` is 1 on the final beat only.
- R3: The first beat's address equals `cmd_addr` exactly, even when it is not aligned to 2^`cmd_size` bytes.
- R4: In an incrementing burst (`cmd_burst`=1), beat N (N≥2) has address A + (N−1)·2^`cmd_size`, where A is the start address rounded down to a multiple of 2^`cmd_size`.
- R5: In a wrapping burst (`cmd_burst`=2), T = 2^`cmd_size`·(`cmd_len`+1) and W is the start address rounded down to a multiple of T. Each later beat is the previous address plus 2^`cmd_size`, and an address that reaches W+T becomes W.
- R6: In a fixed burst (`cmd_burst`=0), every beat repeats the first beat's address, lanes and strobe.
- R7: `beat_lo_lane` is the beat address modulo the bus width in bytes. `beat_hi_lane` is that value rounded down to a multiple of 2^`cmd_size`, plus 2^`cmd_size`−1.
- R8: Bit i of `beat_strb` is 1 exactly when `beat_lo_lane` ≤ i ≤ `beat_hi_lane`.
- R9: A command is refused when `cmd_burst`=3, when 2^`cmd_size` exceeds the bus width, or when it is wrapping and either `cmd_len` is not 1, 3, 7 or 15 or the start address is not a multiple of 2^`cmd_size`. A refused command pulses `cmd_err` for the one cycle after acceptance and starts no beats.
- R10: While `beat_valid` is 1 and `beat_ready` is 0, all beat outputs hold their values.
- R11: A command accepted while the final beat is being advanced presents its first beat in the next cycle, with no idle cycle between the two bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The command is taken at this edge |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_size | input | 3 | Bytes per beat as a power of two |
| cmd_len | input | 4 | Beat count minus one |
| cmd_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| cmd_err | output | 1 | One-cycle pulse after a refused command |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | The consumer takes the beat at this edge |
| beat_addr | output | ADDR_W | Byte address of the beat |
| beat_lo_lane | output | log2(DATA_BYTES) | Lowest active byte lane |
| beat_hi_lane | output | log2(DATA_BYTES) | Highest active byte lane |
| beat_strb | output | DATA_BYTES | One bit per active byte lane |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The two functions that share a clock edge are the retirement of a burst's final beat and the acceptance of the next command, which may be legal or refused. The bench keeps a new command pending while the current burst runs and drives `beat_ready` with a random pattern, so that the handover happens both when the consumer is taking the beat and when it is stalling. A behavioural model expands every command into its expected beats from the address formulas. It is compared with the ports on every cycle, so an idle bubble, a lost beat, a beat that moved during a stall, or a missing error pulse all show up as a mismatch.

// File: rtl/axbg_pkg.sv
package axbg_pkg;

    localparam int SIZE_W = 3;
    localparam int LEN_W  = 4;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'd0,
        BURST_INCR  = 2'd1,
        BURST_WRAP  = 2'd2,
        BURST_RSVD  = 2'd3
    } burst_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [LEN_W-1:0]  len;
        burst_e            kind;
    } burst_ctl_t;

    // beat count of 2, 4, 8 or 16 -> length code is 2^k - 1 with k >= 1
    function automatic logic wrap_len_ok(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] nxt;
        nxt = {1'b0, len} + {{LEN_W{1'b0}}, 1'b1};
        return (len != '0) && ((nxt & {1'b0, len}) == '0);
    endfunction

endpackage

// File: rtl/axbg_cmd_check.sv
module axbg_cmd_check
    import axbg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  burst_ctl_t        ctl,
    output logic              bad
);
    logic [ADDR_W-1:0] size_mask;
    logic              size_bad;
    logic              wrap_bad;

    assign size_mask = ({{(ADDR_W-1){1'b0}}, 1'b1} << ctl.size) - {{(ADDR_W-1){1'b0}}, 1'b1};
    assign size_bad  = int'(ctl.size) > LANE_W;

    always_comb begin
        wrap_bad = 1'b0;
        if (ctl.kind == BURST_WRAP) begin
            wrap_bad = !wrap_len_ok(ctl.len) || ((addr & size_mask) != '0);
        end
    end

    assign bad = size_bad || wrap_bad || (ctl.kind == BURST_RSVD);
endmodule

// File: rtl/axbg_addr_step.sv
module axbg_addr_step
    import axbg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [SIZE_W-1:0] size,
    input  burst_e            kind,
    input  logic [ADDR_W-1:0] win_mask,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] bumped;

    assign step    = {{(ADDR_W-1){1'b0}}, 1'b1} << size;
    assign aligned = cur & ~(step - {{(ADDR_W-1){1'b0}}, 1'b1});
    assign bumped  = aligned + step;

    always_comb begin
        unique case (kind)
            BURST_INCR: nxt = bumped;
            BURST_WRAP: nxt = (cur & ~win_mask) | (bumped & win_mask);
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/axbg_lane_map.sv
module axbg_lane_map
    import axbg_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    parameter int LANE_W     = 3
) (
    input  logic [LANE_W-1:0]     offs,
    input  logic [SIZE_W-1:0]     size,
    output logic [LANE_W-1:0]     lo,
    output logic [LANE_W-1:0]     hi,
    output logic [DATA_BYTES-1:0] strb
);
    logic [LANE_W:0]   span;
    logic [LANE_W-1:0] in_mask;
    logic [LANE_W-1:0] base;
    logic [LANE_W:0]   top;

    assign span    = (LANE_W+1)'(1) << size;
    assign in_mask = LANE_W'(span - (LANE_W+1)'(1));
    assign base    = offs & ~in_mask;
    assign top     = {1'b0, base} + span - (LANE_W+1)'(1);

    assign lo = offs;
    assign hi = top[LANE_W-1:0];

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign strb[i] = (i >= int'(lo)) && (i <= int'(hi));
    end
endmodule

// File: rtl/axbg_burst_gen.sv
module axbg_burst_gen
    import axbg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic [2:0]                    cmd_size,
    input  logic [3:0]                    cmd_len,
    input  logic [1:0]                    cmd_burst,
    output logic                          cmd_err,
    output logic                          beat_valid,
    input  logic                          beat_ready,
    output logic [ADDR_W-1:0]             beat_addr,
    output logic [$clog2(DATA_BYTES)-1:0] beat_lo_lane,
    output logic [$clog2(DATA_BYTES)-1:0] beat_hi_lane,
    output logic [DATA_BYTES-1:0]         beat_strb,
    output logic                          beat_last
);
    localparam int LANE_W = $clog2(DATA_BYTES);

    burst_ctl_t        in_ctl;
    burst_ctl_t        ctl_q;
    logic              busy_q;
    logic              first_q;
    logic              err_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] win_q;
    logic [LEN_W-1:0]  left_q;
    logic              bad;
    logic              take;
    logic              adv;
    logic              final_beat;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] win_new;
    logic [ADDR_W-1:0] size_mask_q;

    assign in_ctl = '{size: cmd_size, len: cmd_len, kind: burst_e'(cmd_burst)};

    axbg_cmd_check #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_check (
        .addr (cmd_addr),
        .ctl  (in_ctl),
        .bad  (bad)
    );

    axbg_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur      (cur_q),
        .size     (ctl_q.size),
        .kind     (ctl_q.kind),
        .win_mask (win_q),
        .nxt      (nxt_addr)
    );

    axbg_lane_map #(.DATA_BYTES(DATA_BYTES), .LANE_W(LANE_W)) u_lanes (
        .offs (cur_q[LANE_W-1:0]),
        .size (ctl_q.size),
        .lo   (beat_lo_lane),
        .hi   (beat_hi_lane),
        .strb (beat_strb)
    );

    assign final_beat = busy_q && (left_q == '0);
    assign adv        = busy_q && beat_ready;
    assign cmd_ready  = !busy_q || (beat_ready && final_beat);
    assign take       = cmd_valid && cmd_ready;

    // wrap window: total burst bytes minus one
    assign win_new = ((ADDR_W'(cmd_len) + ADDR_W'(1)) << cmd_size) - ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
            cur_q   <= '0;
            win_q   <= '0;
            left_q  <= '0;
            ctl_q   <= '{size: '0, len: '0, kind: BURST_FIXED};
        end else begin
            err_q <= take && bad;
            if (take) begin
                busy_q <= !bad;
                if (!bad) begin
                    first_q <= 1'b1;
                    cur_q   <= cmd_addr;
                    win_q   <= win_new;
                    left_q  <= cmd_len;
                    ctl_q   <= in_ctl;
                end
            end else if (adv) begin
                if (final_beat) begin
                    busy_q <= 1'b0;
                end else begin
                    first_q <= 1'b0;
                    cur_q   <= nxt_addr;
                    left_q  <= left_q - LEN_W'(1);
                end
            end
        end
    end

    assign cmd_err    = err_q;
    assign beat_valid = busy_q;
    assign beat_addr  = cur_q;
    assign beat_last  = final_beat;

    assign size_mask_q = ({{(ADDR_W-1){1'b0}}, 1'b1} << ctl_q.size) - {{(ADDR_W-1){1'b0}}, 1'b1};

    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |-> cmd_ready);

    // R2
    last_in_beat_chk: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);

    // R4
    later_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !first_q && ctl_q.kind != BURST_FIXED) |-> ((beat_addr & size_mask_q) == '0));

    // R8
    strb_span_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> ($countones(beat_strb) == int'(beat_hi_lane) - int'(beat_lo_lane) + 1));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !beat_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_strb) && $stable(beat_last)));
endmodule

// File: tb/axbg_burst_gen_test.sv
module axbg_burst_gen_test;
    localparam int AW = 32;
    localparam int DB = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [2:0]    cmd_size = '0;
    logic [3:0]    cmd_len = '0;
    logic [1:0]    cmd_burst = '0;
    logic          cmd_err;
    logic          beat_valid;
    logic          beat_ready = 1'b0;
    logic [AW-1:0] beat_addr;
    logic [LW-1:0] beat_lo_lane;
    logic [LW-1:0] beat_hi_lane;
    logic [DB-1:0] beat_strb;
    logic          beat_last;

    axbg_burst_gen #(.ADDR_W(AW), .DATA_BYTES(DB)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .cmd_len(cmd_len), .cmd_burst(cmd_burst), .cmd_err(cmd_err),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
        .beat_lo_lane(beat_lo_lane), .beat_hi_lane(beat_hi_lane),
        .beat_strb(beat_strb), .beat_last(beat_last)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        longint unsigned addr;
        int              lo;
        int              hi;
        logic [DB-1:0]   strb;
        bit              last;
        string           tag;
    } beat_t;

    beat_t q[$];
    bit    m_err = 0;
    bit    stall_prev = 0;
    bit    checking = 0;
    int    rdy_mode = 0;
    int    tests = 0;
    int    fails = 0;
    bit    done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit refused(longint unsigned a, int sz, int ln, int bt);
        int nb = 1 << sz;
        if (bt == 3) return 1;
        if (nb > DB) return 1;
        if (bt == 2 && !(ln == 1 || ln == 3 || ln == 7 || ln == 15)) return 1;
        if (bt == 2 && (a % nb) != 0) return 1;
        return 0;
    endfunction

    task automatic expand(input longint unsigned a, input int sz, input int ln, input int bt);
        longint unsigned nb, al, tot, wb, ad;
        int beats;
        beat_t b;
        nb = longint'(1) << sz;
        beats = ln + 1;
        al = (a / nb) * nb;
        tot = nb * beats;
        wb = (a / tot) * tot;
        for (int n = 1; n <= beats; n++) begin
            if (bt == 0 || n == 1) ad = a;
            else ad = al + (n - 1) * nb;
            if (bt == 2 && n > 1) ad = wb + ((ad - wb) % tot);
            ad = ad & 64'hFFFF_FFFF;
            if (n == 1 || bt == 0) begin
                b.lo = int'(a % DB);
                b.hi = int'(al + nb - 1 - (a / DB) * DB);
            end else begin
                b.lo = int'(ad % DB);
                b.hi = b.lo + int'(nb) - 1;
            end
            for (int i = 0; i < DB; i++) b.strb[i] = (i >= b.lo) && (i <= b.hi);
            b.addr = ad;
            b.last = (n == beats);
            if (n == 1) b.tag = "R3";
            else if (bt == 0) b.tag = "R6";
            else if (bt == 2) b.tag = "R5";
            else b.tag = "R4";
            q.push_back(b);
        end
    endtask

    // behavioural reference, updated at every edge from the inputs then applied
    always @(posedge clk) begin
        bit rdy;
        if (rst) begin
            q.delete();
            m_err = 0;
            stall_prev = 0;
        end else begin
            rdy = (q.size() == 0) || (beat_ready && q.size() == 1);
            stall_prev = (q.size() > 0) && !beat_ready;
            if (q.size() > 0 && beat_ready) void'(q.pop_front());
            m_err = 0;
            if (cmd_valid && rdy) begin
                if (refused(cmd_addr, cmd_size, cmd_len, cmd_burst)) m_err = 1;
                else expand(cmd_addr, cmd_size, cmd_len, cmd_burst);
            end
        end
    end

    always @(negedge clk) begin
        bit    exp_rdy;
        string at;
        if (checking && !rst && !done) begin
            exp_rdy = (q.size() == 0) || (beat_ready && q.size() == 1);
            chk(beat_valid == (q.size() > 0), "R1/R11", "beat_valid", beat_valid, q.size() > 0);
            chk(cmd_ready == exp_rdy, "R1/R11", "cmd_ready", cmd_ready, exp_rdy);
            chk(cmd_err == m_err, "R9", "cmd_err", cmd_err, m_err);
            if (beat_valid && q.size() > 0) begin
                at = stall_prev ? {q[0].tag, "/R10"} : q[0].tag;
                chk(longint'(beat_addr) == q[0].addr, at, "beat_addr", beat_addr, q[0].addr);
                chk(int'(beat_lo_lane) == q[0].lo, "R7", "beat_lo_lane", beat_lo_lane, q[0].lo);
                chk(int'(beat_hi_lane) == q[0].hi, "R7", "beat_hi_lane", beat_hi_lane, q[0].hi);
                chk(beat_strb == q[0].strb, "R8", "beat_strb", beat_strb, q[0].strb);
                chk(beat_last == q[0].last, "R2", "beat_last", beat_last, q[0].last);
            end
        end
    end

    // consumer side
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rdy_mode == 0) beat_ready = 1'b1;
            else beat_ready = ($urandom_range(0, 2) != 0);
        end
    end

    task automatic send(input longint unsigned a, input int sz, input int ln, input int bt);
        @(posedge clk);
        #1;
        cmd_valid = 1'b1;
        cmd_addr  = a[AW-1:0];
        cmd_size  = 3'(sz);
        cmd_len   = 4'(ln);
        cmd_burst = 2'(bt);
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (q.size() != 0 || beat_valid);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(beat_valid == 1'b0, "R1", "reset beat_valid", beat_valid, 0);
        chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
        chk(cmd_err == 1'b0, "R1", "reset cmd_err", cmd_err, 0);
        checking = 1;

        rdy_mode = 0;
        send(32'h100, 2, 3, 1);     // R4 aligned incrementing
        send(32'h1003, 2, 4, 1);    // R3 R7 unaligned start
        send(32'h2005, 3, 2, 1);    // R7 partial first beat on full width
        send(32'h3011, 0, 15, 1);   // byte beats, 16 of them
        drain();
        send(32'h38, 2, 3, 2);      // R5 fold after two beats
        send(32'h1F0, 3, 7, 2);     // R5 64-byte window
        send(32'h400, 1, 1, 2);     // R5 two-beat wrap
        send(32'h107, 1, 3, 0);     // R6 fixed, unaligned
        send(32'h20, 3, 2, 0);      // R6 fixed, full width
        drain();
        send(32'h40, 2, 2, 2);      // R9 wrap with 3 beats
        send(32'h42, 2, 3, 2);      // R9 wrap unaligned
        send(32'h80, 1, 1, 3);      // R9 reserved kind
        send(32'h80, 4, 0, 1);      // R9 size wider than bus
        send(32'h500, 2, 1, 1);     // legal right after refusals
        drain();

        rdy_mode = 1;               // R10 R11 stalls and handovers
        for (int k = 0; k < 40; k++) begin
            int bt = $urandom_range(0, 3);
            int sz = $urandom_range(0, 4);
            int ln = $urandom_range(0, 15);
            longint unsigned a = longint'($urandom_range(0, 32'hFFFF));
            if (k % 3 == 0) begin
                bt = 2;
                sz = $urandom_range(0, 3);
                ln = (2 << $urandom_range(0, 3)) - 1;
                a = (a >> sz) << sz;
            end
            send(a, sz, ln, bt);
        end
        drain();
        rdy_mode = 0;
        send(32'hFFF8, 3, 1, 1);
        send(32'hFFFF_FFF0, 2, 3, 2);
        drain();
        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        fails++;
        tests++;
        $display("FAIL R1 watchdog: actual %0d expected 0 cycles left", 0);
        summary();
    end
endmodule